// File: doc/BRIEF.md
# Cache-Line Instruction Group Extractor

This block sits in the fetch stage of a pipelined core. It holds the program-counter pair of the fetching thread: the address of the current instruction and the address that follows it. In a cycle where `go` is raised, it takes a fetched cache line. It cuts consecutive 32-bit instruction words out of that line, starting at the current PC, and places them in numbered slots of a bundle bound for decode. For every candidate slot it presents the slot's address on `look_pc`. An external next-PC predictor answers combinationally on `pred_npc`. The group ends on whichever of these comes first: the fetch width is used up, the cache line ends, or an instruction leaves the sequential path.

Every emitted instruction receives a sequence number from a running counter. After the group, the PC pair advances to the predicted pair that follows the last emitted instruction. If the fetch reports a translation fault, the block emits no real instruction. It sends one no-op that carries the fault flag and parks the thread in a trap-wait state. A quiesce instruction is emitted and then parks the thread in a quiesce-wait state. Only a redirect, which loads a new PC pair, brings a parked thread back.

Top module: `fetch_group_extract`

## Requirements
- R1: After reset, `out_valid` is 0, `thr_state` is 0 (run), `cur_pc` is RESET_PC, `cur_npc` is RESET_PC+4 and `seq_next` is 0.
- R2: Slot 0 holds the line word at byte offset (`cur_pc` mod LINE_BYTES) with the two low bits cleared. Word k of the line is `line_data[32k+31:32k]`, and slot i holds word (start word + i). LINE_BYTES is a power of two, at least 8, and a multiple of 4.
- R3: Extraction stops at the end of the line. No slot uses a word index at or above LINE_BYTES/4.
- R4: A group never holds more than FETCH_W instructions, and `out_count` never exceeds FETCH_W.
- R5: After emitting a slot whose address pair (pc, npc) has npc ≠ pc+4, or whose predicted next PC `pred_npc[i]` ≠ npc+4, the group ends with that slot included. Slot i reports `out_next` = npc and `out_nnext` = `pred_npc[i]`. The address of slot i is `cur_pc`+4i, which is also driven on `look_pc[i]`.
- R6: Slot i carries sequence number `seq_next`+i, taken before the fetch. `seq_next` then grows by the number of slots emitted, modulo 2^SEQ_W.
- R7: After a fault-free group, `cur_pc`/`cur_npc` become the npc and the predicted next PC of the last emitted slot.
- R8: A fetch with `fetch_fault` high emits exactly one slot. That slot holds NOP_WORD at address `cur_pc`, with `out_fault` 1, `out_next` = `cur_npc` and `out_nnext` = `cur_npc`+4. The PC pair is unchanged, `seq_next` grows by 1, and `thr_state` becomes 1 (trap wait).
- R9: A slot whose word equals QUIESCE_WORD is emitted and counted, then ends the group. The PC pair advances past it and `thr_state` becomes 2 (quiesce wait).
- R10: While `thr_state` is not 0, `go` is ignored: no bundle is produced and the PC pair and `seq_next` hold. A redirect loads `redir_pc`/`redir_npc` and sets `thr_state` to 0. It takes priority over a `go` in the same cycle, which then produces no bundle.
- R11: Bundle outputs appear on the clock edge that samples `go`, and they last one cycle. `out_valid` is 1 exactly when `out_count` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| redir_valid | input | 1 | Load a new PC pair and resume |
| redir_pc | input | PC_W | PC loaded on redirect |
| redir_npc | input | PC_W | Next PC loaded on redirect |
| go | input | 1 | Line present; extract a group this cycle |
| line_data | input | LINE_BYTES*8 | Fetched cache line, word k at bits 32k+31:32k |
| fetch_fault | input | 1 | Translation fault on this fetch |
| look_pc | output | FETCH_W*PC_W | Address of each candidate slot, sent to the predictor |
| pred_npc | input | FETCH_W*PC_W | Predicted next PC for each candidate slot |
| out_valid | output | 1 | Bundle holds at least one slot |
| out_count | output | $clog2(FETCH_W+1) | Number of filled slots |
| out_word | output | FETCH_W*32 | Instruction word per slot |
| out_pc | output | FETCH_W*PC_W | Address per slot |
| out_seq | output | FETCH_W*SEQ_W | Sequence number per slot |
| out_next | output | FETCH_W*PC_W | Next PC recorded with each slot |
| out_nnext | output | FETCH_W*PC_W | Predicted PC after next, per slot |
| out_fault | output | 1 | Slot 0 is a fault-carrying no-op |
| cur_pc | output | PC_W | Committed PC |
| cur_npc | output | PC_W | Committed next PC |
| thr_state | output | 2 | 0 run, 1 trap wait, 2 quiesce wait |
| seq_next | output | SEQ_W | Next sequence number to hand out |

## Verification
The bench builds the block with LINE_BYTES=32 (eight words), FETCH_W=4 and SEQ_W=8. With a four-wide group inside an eight-word line, a start at word 4 or below makes the width the binding limit. A start at word 5 or above makes the line end bind first, down to a single slot at word 7. The narrow sequence field wraps several times during the random run, so the modulo arithmetic of the numbering is exercised. Branch masks, nonsequential redirect pairs, quiesce words and faults are placed in every slot position.

// File: rtl/fetch_group_extract.sv
module fetch_group_extract #(
  parameter int PC_W          = 32,
  parameter int LINE_BYTES    = 32,
  parameter int FETCH_W       = 4,
  parameter int SEQ_W         = 16,
  parameter logic [31:0] RESET_PC     = 32'h0000_1000,
  parameter logic [31:0] NOP_WORD     = 32'h0000_0013,
  parameter logic [31:0] QUIESCE_WORD = 32'h1050_0073
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          redir_valid,
  input  logic [PC_W-1:0]               redir_pc,
  input  logic [PC_W-1:0]               redir_npc,
  input  logic                          go,
  input  logic [LINE_BYTES*8-1:0]       line_data,
  input  logic                          fetch_fault,
  output logic [FETCH_W*PC_W-1:0]       look_pc,
  input  logic [FETCH_W*PC_W-1:0]       pred_npc,
  output logic                          out_valid,
  output logic [$clog2(FETCH_W+1)-1:0]  out_count,
  output logic [FETCH_W*32-1:0]         out_word,
  output logic [FETCH_W*PC_W-1:0]       out_pc,
  output logic [FETCH_W*SEQ_W-1:0]      out_seq,
  output logic [FETCH_W*PC_W-1:0]       out_next,
  output logic [FETCH_W*PC_W-1:0]       out_nnext,
  output logic                          out_fault,
  output logic [PC_W-1:0]               cur_pc,
  output logic [PC_W-1:0]               cur_npc,
  output logic [1:0]                    thr_state,
  output logic [SEQ_W-1:0]              seq_next
);
  localparam int WORDS = LINE_BYTES / 4;
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CNT_W = $clog2(FETCH_W + 1);
  localparam logic [1:0] ST_RUN  = 2'd0;
  localparam logic [1:0] ST_TRAP = 2'd1;
  localparam logic [1:0] ST_QUI  = 2'd2;

  initial begin
    line_size_chk: assert (LINE_BYTES >= 8 && LINE_BYTES % 4 == 0 && (1 << OFF_W) == LINE_BYTES)
      else $error("LINE_BYTES must be a power of two, at least 8");
  end

  logic [PC_W-1:0] pc_q, npc_q;
  logic [1:0]      st_q;
  logic [SEQ_W-1:0] seq_q;

  wire is_run  = (st_q == ST_RUN) && !redir_valid;
  wire do_flt  = go && is_run && fetch_fault;
  wire do_grp  = go && is_run && !fetch_fault;

  genvar g;
  generate
    for (g = 0; g < FETCH_W; g++) begin : g_look
      assign look_pc[g*PC_W +: PC_W] = pc_q + PC_W'(4 * g);
    end
  endgenerate

  logic [FETCH_W*32-1:0]   s_word;
  logic [FETCH_W*PC_W-1:0] s_next, s_nnext;
  logic [CNT_W-1:0]        cnt_c;
  logic [PC_W-1:0]         end_pc, end_npc;
  logic                    qhit;

  always_comb begin
    int              wp;
    logic [PC_W-1:0] p, np, pr;
    logic [31:0]     w;
    logic            live, take;
    p = pc_q;
    np = npc_q;
    live = do_grp;
    cnt_c = '0;
    end_pc = pc_q;
    end_npc = npc_q;
    qhit = 1'b0;
    s_word = '0;
    s_next = '0;
    s_nnext = '0;
    for (int i = 0; i < FETCH_W; i++) begin
      wp = int'(pc_q[OFF_W-1:2]) + i;
      w = line_data[32*(wp % WORDS) +: 32];
      pr = pred_npc[i*PC_W +: PC_W];
      take = live && (wp < WORDS);
      if (take) begin
        s_word[i*32 +: 32] = w;
        s_next[i*PC_W +: PC_W] = np;
        s_nnext[i*PC_W +: PC_W] = pr;
        cnt_c = cnt_c + CNT_W'(1);
        end_pc = np;
        end_npc = pr;
        if (w == QUIESCE_WORD) qhit = 1'b1;
      end
      live = take && (np == p + PC_W'(4)) && (pr == np + PC_W'(4)) && (w != QUIESCE_WORD);
      p = np;
      np = pr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= PC_W'(RESET_PC);
      npc_q <= PC_W'(RESET_PC) + PC_W'(4);
      st_q <= ST_RUN;
      seq_q <= '0;
      out_valid <= 1'b0;
      out_count <= '0;
      out_fault <= 1'b0;
      out_word <= '0;
      out_pc <= '0;
      out_next <= '0;
      out_nnext <= '0;
    end else begin
      out_valid <= 1'b0;
      out_count <= '0;
      out_fault <= 1'b0;
      if (redir_valid) begin
        pc_q <= redir_pc;
        npc_q <= redir_npc;
        st_q <= ST_RUN;
      end else if (do_flt) begin
        out_valid <= 1'b1;
        out_count <= CNT_W'(1);
        out_fault <= 1'b1;
        out_word <= {{(FETCH_W-1)*32{1'b0}}, NOP_WORD};
        out_pc <= look_pc;
        out_next <= {{(FETCH_W-1)*PC_W{1'b0}}, npc_q};
        out_nnext <= {{(FETCH_W-1)*PC_W{1'b0}}, npc_q + PC_W'(4)};
        seq_q <= seq_q + SEQ_W'(1);
        st_q <= ST_TRAP;
      end else if (do_grp) begin
        out_valid <= (cnt_c != '0);
        out_count <= cnt_c;
        out_word <= s_word;
        out_pc <= look_pc;
        out_next <= s_next;
        out_nnext <= s_nnext;
        pc_q <= end_pc;
        npc_q <= end_npc;
        seq_q <= seq_q + SEQ_W'(cnt_c);
        st_q <= qhit ? ST_QUI : ST_RUN;
      end
    end
  end

  generate
    for (g = 0; g < FETCH_W; g++) begin : g_seq
      always_ff @(posedge clk) begin
        if (!rst_n) out_seq[g*SEQ_W +: SEQ_W] <= '0;
        else if (do_flt || do_grp) out_seq[g*SEQ_W +: SEQ_W] <= seq_q + SEQ_W'(g);
      end
    end
  endgenerate

  assign cur_pc = pc_q;
  assign cur_npc = npc_q;
  assign thr_state = st_q;
  assign seq_next = seq_q;

  // R4
  width_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_count <= CNT_W'(FETCH_W));

  // R11
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == (out_count != '0));

  // R8
  fault_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && fetch_fault && !redir_valid && thr_state == ST_RUN)
      |=> (thr_state == ST_TRAP && out_fault && out_count == CNT_W'(1) && $stable(cur_pc) && $stable(cur_npc)));

  // R10
  park_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_state != ST_RUN && !redir_valid)
      |=> (!out_valid && $stable(cur_pc) && $stable(cur_npc) && $stable(seq_next)));

  // R6
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (seq_next == $past(seq_next) + SEQ_W'(out_count)));
endmodule

// File: tb/sim_fetch_group_extract.sv
module sim_fetch_group_extract;
  localparam int PC_W = 32, LB = 32, FW = 4, SW = 8, CW = 3;
  localparam logic [31:0] NOPW = 32'h0000_0013;
  localparam logic [31:0] QW = 32'h1050_0073;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic redir_valid = 0, go = 0, fetch_fault = 0;
  logic [PC_W-1:0] redir_pc = 0, redir_npc = 0;
  logic [LB*8-1:0] line_data = '0;
  logic [FW*PC_W-1:0] look_pc, pred_npc, out_pc, out_next, out_nnext;
  logic out_valid, out_fault;
  logic [CW-1:0] out_count;
  logic [FW*32-1:0] out_word;
  logic [FW*SW-1:0] out_seq;
  logic [PC_W-1:0] cur_pc, cur_npc;
  logic [1:0] thr_state;
  logic [SW-1:0] seq_next;

  fetch_group_extract #(.PC_W(PC_W), .LINE_BYTES(LB), .FETCH_W(FW), .SEQ_W(SW),
    .RESET_PC(32'h1000), .NOP_WORD(NOPW), .QUIESCE_WORD(QW)) u0 (.*);

  int checks = 0, errors = 0;
  logic [PC_W-1:0] m_pc, m_npc;
  logic [1:0] m_st;
  logic [SW-1:0] m_seq;
  logic [FW-1:0] br_mask = '0;

  always_comb begin
    for (int i = 0; i < FW; i++) begin
      logic [PC_W-1:0] after;
      after = (i == 0) ? m_npc : look_pc[i*PC_W +: PC_W] + 4;
      pred_npc[i*PC_W +: PC_W] = br_mask[i] ? 32'h9000 + 32'(16 * i) : after + 4;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic check_state(input string rq);
    chk(cur_pc == m_pc, rq, "cur_pc", 64'(cur_pc), 64'(m_pc));
    chk(cur_npc == m_npc, rq, "cur_npc", 64'(cur_npc), 64'(m_npc));
    chk(thr_state == m_st, rq, "state", 64'(thr_state), 64'(m_st));
    chk(seq_next == m_seq, rq, "seq_next", 64'(seq_next), 64'(m_seq));
  endtask

  // one fetch cycle; we are at a negedge on entry and on exit
  task automatic fetch(input logic [LB*8-1:0] line, input bit flt, input logic [FW-1:0] mask, input string rq);
    int e_cnt;
    logic [31:0] e_w[FW];
    logic [PC_W-1:0] e_pc[FW], e_nx[FW], e_nn[FW];
    logic [PC_W-1:0] p, np, pr, n_pc, n_npc;
    logic [1:0] n_st;
    logic [SW-1:0] s0;
    bit parked;
    line_data = line; fetch_fault = flt; br_mask = mask; go = 1;
    parked = (m_st != 2'd0);
    e_cnt = 0; p = m_pc; np = m_npc; n_pc = m_pc; n_npc = m_npc; n_st = m_st; s0 = m_seq;
    if (!parked && flt) begin
      e_cnt = 1; e_w[0] = NOPW; e_pc[0] = m_pc; e_nx[0] = m_npc; e_nn[0] = m_npc + 4; n_st = 2'd1;
    end else if (!parked) begin
      n_st = 2'd0;
      for (int i = 0; i < FW; i++) begin
        int wi;
        wi = int'(m_pc[4:2]) + i;
        if (wi >= LB / 4) break;
        pr = mask[i] ? 32'h9000 + 32'(16 * i) : np + 4;
        e_w[i] = line[32*wi +: 32]; e_pc[i] = p; e_nx[i] = np; e_nn[i] = pr;
        e_cnt++;
        n_pc = np; n_npc = pr;
        if (e_w[i] == QW) begin n_st = 2'd2; break; end
        if (np != p + 4 || pr != np + 4) break;
        p = np; np = pr;
      end
    end
    @(posedge clk); #1;
    go = 0; fetch_fault = 0;
    @(negedge clk);
    chk(out_valid == (e_cnt != 0), parked ? "R10" : "R11", "out_valid", 64'(out_valid), 64'(e_cnt != 0));
    chk(int'(out_count) == e_cnt, rq, "out_count", 64'(out_count), 64'(e_cnt));
    if (!parked) chk(out_fault == flt, "R8", "out_fault", 64'(out_fault), 64'(flt));
    for (int i = 0; i < e_cnt; i++) begin
      chk(out_word[i*32 +: 32] == e_w[i], "R2", $sformatf("word%0d", i), 64'(out_word[i*32 +: 32]), 64'(e_w[i]));
      chk(out_pc[i*PC_W +: PC_W] == e_pc[i], "R5", $sformatf("pc%0d", i), 64'(out_pc[i*PC_W +: PC_W]), 64'(e_pc[i]));
      chk(out_next[i*PC_W +: PC_W] == e_nx[i], "R5", $sformatf("next%0d", i), 64'(out_next[i*PC_W +: PC_W]), 64'(e_nx[i]));
      chk(out_nnext[i*PC_W +: PC_W] == e_nn[i], "R5", $sformatf("nnext%0d", i), 64'(out_nnext[i*PC_W +: PC_W]), 64'(e_nn[i]));
      chk(out_seq[i*SW +: SW] == s0 + SW'(i), "R6", $sformatf("seq%0d", i), 64'(out_seq[i*SW +: SW]), 64'(s0 + SW'(i)));
    end
    m_pc = n_pc; m_npc = n_npc; m_st = n_st; m_seq = m_seq + SW'(e_cnt);
    check_state(flt ? "R8" : "R7");
    @(negedge clk);
    chk(!out_valid, "R11", "valid one cycle", 64'(out_valid), 64'(0));
  endtask

  task automatic redirect(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] npc, input bit with_go);
    redir_valid = 1; redir_pc = pc; redir_npc = npc; go = with_go;
    @(posedge clk); #1;
    redir_valid = 0; go = 0;
    @(negedge clk);
    m_pc = pc; m_npc = npc; m_st = 2'd0;
    chk(!out_valid, "R10", "no bundle on redirect", 64'(out_valid), 64'(0));
    check_state("R10");
  endtask

  function automatic logic [LB*8-1:0] rand_line(input int qslot);
    logic [LB*8-1:0] l;
    for (int k = 0; k < LB / 4; k++) begin
      l[32*k +: 32] = $urandom;
      if (l[32*k +: 32] == QW) l[32*k +: 32] = 32'h1;
    end
    if (qslot >= 0) l[32*qslot +: 32] = QW;
    return l;
  endfunction

  initial begin
    #200000000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [LB*8-1:0] ln;
    void'($urandom(32'd1234));
    m_pc = 32'h1000; m_npc = 32'h1004; m_st = 0; m_seq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!out_valid, "R1", "valid after reset", 64'(out_valid), 64'(0));
    check_state("R1");
    for (int k = 0; k < LB / 4; k++) ln[32*k +: 32] = 32'hA000_0000 + 32'(k);
    fetch(ln, 0, 4'b0000, "R4");                  // word 0, width binds
    redirect(32'h1014, 32'h1018, 0);
    fetch(ln, 0, 4'b0000, "R3");                  // word 5, line end after 3
    redirect(32'h101C, 32'h1020, 0);
    fetch(ln, 0, 4'b0000, "R3");                  // last word only
    redirect(32'h1006, 32'h100A, 0);
    fetch(ln, 0, 4'b0000, "R2");                  // low bits cleared for offset
    redirect(32'h1000, 32'h1004, 0);
    fetch(ln, 0, 4'b0010, "R5");                  // predicted branch in slot 1
    redirect(32'h1000, 32'h1040, 0);
    fetch(ln, 0, 4'b0000, "R5");                  // nonsequential npc stops at slot 0
    redirect(32'h1000, 32'h1004, 0);
    ln[32*2 +: 32] = QW;
    fetch(ln, 0, 4'b0000, "R9");                  // quiesce in slot 2
    fetch(ln, 0, 4'b0000, "R10");                 // ignored while parked
    redirect(32'h1008, 32'h100C, 1);              // redirect wins over go
    fetch(ln, 1, 4'b0000, "R8");                  // fault
    fetch(ln, 0, 4'b0000, "R10");                 // ignored in trap wait
    redirect(32'h1010, 32'h1014, 0);
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom_range(0, 9);
      if (r == 0 || m_st != 0) begin
        logic [PC_W-1:0] a;
        a = 32'h1000 + ($urandom_range(0, 1023) << 2);
        redirect(a, ($urandom_range(0, 4) == 0) ? a + 32'h80 : a + 4, $urandom_range(0, 1));
      end
      fetch(rand_line(($urandom_range(0, 5) == 0) ? $urandom_range(0, 7) : -1),
            $urandom_range(0, 12) == 0, 4'($urandom_range(0, 15) & $urandom_range(0, 15)), "R7");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule